// File: doc/BRIEF.md
# Pin I/O Block with Interrupt Window

This block gives software control over a bank of general-purpose pins through a small 32-bit register port. Each pin has a drive-enable bit, a drive-value bit and a sampled input bit. The pad inputs pass through a two-stage synchronizer before software can read them or they can feed any interrupt logic.

A fixed, contiguous group of pins can also act as interrupt sources. Each pin in this group is routed to its own interrupt line by setting one bit of a two-bit-per-pin function field. Each interrupt index has a sense bit. When the sense bit is 1 the pin passes through unchanged. When it is 0 the pin is inverted. Every interrupt line therefore leaves the block active-high, ready for a downstream controller that only understands high or rising requests.

The register port is single-cycle. A write takes effect at the clock edge where `wr_en` is high. Read data is a combinational function of `addr`. Because the block has no bit-level write support, software updates a single pin with a read-modify-write of the whole word.

Top module: `gpio_irqwin`

## Requirements
- R1: Synchronous active-low reset clears every register, so every pad is released (`pad_oe` = 0) and every `irq_out` bit is 0. All mapped offsets read as 0 after reset.
- R2: A write to offset 0x29C sets the drive-enable bits and a write to 0x2A0 sets the drive-value bits, with pin p at bit p. Both read back in bits 0..21 with zeros above. `pad_oe` equals the drive-enable register and `pad_out` equals the drive-value register.
- R3: A read of offset 0x2A4 returns the pad inputs, synchronized through two flops, in bits 0..21 and zeros above. A pad change is not yet visible after one clock edge and is visible after two. Writes to this offset have no effect.
- R4: Offset 0x294 is a 32-bit function-select register that reads back as written. Bit 2*p enables interrupt routing for pin p. Interrupt index n belongs to pin 8+n, for n = 0..5.
- R5: Offset 0x290 holds one sense bit per interrupt index at bit n, and only bits 0..5 are stored. For a routed index, `irq_out[n]` equals pin 8+n when the sense bit is 1, and the inverse of the pin when it is 0.
- R6: When the routing bit of an index is clear, its `irq_out` bit is 0 whatever the pin and sense values are.
- R7: Pins outside 8..13 never drive an interrupt, even when their function-select bits are set.
- R8: A write to an unmapped offset changes no register, and a read from an unmapped offset returns 0.
- R9: A write changes only the register at its offset. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | 22 | Raw pad input levels |
| pad_out | output | 22 | Value driven onto each pad |
| pad_oe | output | 22 | Pad drive enable; 0 means high impedance |
| irq_out | output | 6 | Active-high interrupt lines, one per window index |

## Verification
The bench samples the input register one edge after a pad change and again after two edges. A design with a missing or extra synchronizer stage fails one of these two samples. The sense stage is checked with pad patterns that mix high and low window pins under a mixed sense word. A design that inverted the wrong sense value, or mapped an index to a pin off by one, would give a visibly wrong interrupt vector. The bench also sets function-select bits only for pins below and above the window and toggles every pad. It then writes an unmapped offset and the read-only input offset, and reads back every other register. A design that decoded loosely, or let a stray routing bit reach `irq_out`, would leave a non-zero interrupt vector or a changed register.

// File: rtl/gpio_irqwin_pkg.sv
// Package: shared constants, register selector type and address decode.
// Assumes word-aligned byte offsets on a 12-bit address.
package gpio_irqwin_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h290;
    localparam logic [ADDR_W-1:0] OFS_FSEL  = 12'h294;
    localparam logic [ADDR_W-1:0] OFS_DRVEN = 12'h29C;
    localparam logic [ADDR_W-1:0] OFS_DRVAL = 12'h2A0;
    localparam logic [ADDR_W-1:0] OFS_PINS  = 12'h2A4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_FSEL,
        SEL_DRVEN,
        SEL_DRVAL,
        SEL_PINS
    } regsel_e;

    // Map a byte offset onto the register it names.
    function automatic regsel_e decode(input logic [ADDR_W-1:0] a);
        regsel_e s;
        case (a)
            OFS_SENSE: s = SEL_SENSE;
            OFS_FSEL:  s = SEL_FSEL;
            OFS_DRVEN: s = SEL_DRVEN;
            OFS_DRVAL: s = SEL_DRVAL;
            OFS_PINS:  s = SEL_PINS;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_irqwin_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no bus coherency is promised.
module gpio_irqwin_sync #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift pad levels through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_irqwin_regs.sv
// Register file: sense, function-select, drive-enable and drive-value
// registers plus the read multiplexer. Extracts the routing enable bit
// of each interrupt index from the function-select word.
// Assumes 2*(IRQ_BASE+IRQ_COUNT-1) < DATA_W and NUM_PINS < DATA_W.
module gpio_irqwin_regs
    import gpio_irqwin_pkg::*;
#(
    parameter int NUM_PINS  = 22,
    parameter int IRQ_COUNT = 6,
    parameter int IRQ_BASE  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_PINS-1:0]  pin_sync,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_PINS-1:0]  drv_en_q,
    output logic [NUM_PINS-1:0]  drv_val_q,
    output logic [IRQ_COUNT-1:0] sense_q,
    output logic [IRQ_COUNT-1:0] irq_en
);

    logic [DATA_W-1:0] fsel_q;
    regsel_e           sel;

    assign sel = decode(addr);

    // Update the addressed register on a write; others hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q   <= '0;
            fsel_q    <= '0;
            drv_en_q  <= '0;
            drv_val_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_SENSE: sense_q   <= wdata[IRQ_COUNT-1:0];
                SEL_FSEL:  fsel_q    <= wdata;
                SEL_DRVEN: drv_en_q  <= wdata[NUM_PINS-1:0];
                SEL_DRVAL: drv_val_q <= wdata[NUM_PINS-1:0];
                default:   ;
            endcase
        end
    end

    // Return the addressed register, zero-extended; unmapped reads give 0.
    always_comb begin
        case (sel)
            SEL_SENSE: rdata = DATA_W'(sense_q);
            SEL_FSEL:  rdata = fsel_q;
            SEL_DRVEN: rdata = DATA_W'(drv_en_q);
            SEL_DRVAL: rdata = DATA_W'(drv_val_q);
            SEL_PINS:  rdata = DATA_W'(pin_sync);
            default:   rdata = '0;
        endcase
    end

    // Pick the routing bit at position 2*pin for every window index.
    for (genvar n = 0; n < IRQ_COUNT; n++) begin : g_en
        localparam int SEL_BIT = 2 * (IRQ_BASE + n);
        assign irq_en[n] = fsel_q[SEL_BIT];
    end

endmodule

// File: rtl/gpio_irqwin_irqmap.sv
// Interrupt window: normalizes each routed window pin to active-high
// using its sense bit, and holds unrouted indices low.
// Assumes window pins arrive already synchronized.
module gpio_irqwin_irqmap #(
    parameter int IRQ_COUNT = 6
) (
    input  logic [IRQ_COUNT-1:0] win_pins,
    input  logic [IRQ_COUNT-1:0] sense,
    input  logic [IRQ_COUNT-1:0] irq_en,
    output logic [IRQ_COUNT-1:0] irq_out
);

    // One polarity stage per index: pass when sense is 1, invert when 0.
    for (genvar n = 0; n < IRQ_COUNT; n++) begin : g_irq
        logic level;
        assign level      = sense[n] ? win_pins[n] : ~win_pins[n];
        assign irq_out[n] = irq_en[n] & level;
    end

endmodule

// File: rtl/gpio_irqwin.sv
// Top: pin I/O block with a fixed interrupt window. Ties together the
// synchronizer, register file and polarity stage. Pads are driven from
// the drive-value register while drive-enable is set.
// Assumes a single clock domain for the register port.
module gpio_irqwin
    import gpio_irqwin_pkg::*;
#(
    parameter int NUM_PINS  = 22,
    parameter int IRQ_COUNT = 6,
    parameter int IRQ_BASE  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [IRQ_COUNT-1:0] irq_out
);

    logic [NUM_PINS-1:0]  pin_sync;
    logic [NUM_PINS-1:0]  drv_en_q;
    logic [NUM_PINS-1:0]  drv_val_q;
    logic [IRQ_COUNT-1:0] sense_q;
    logic [IRQ_COUNT-1:0] irq_en;
    logic [IRQ_COUNT-1:0] win_pins;

    gpio_irqwin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_irqwin_regs #(
        .NUM_PINS  (NUM_PINS),
        .IRQ_COUNT (IRQ_COUNT),
        .IRQ_BASE  (IRQ_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .pin_sync  (pin_sync),
        .rdata     (rdata),
        .drv_en_q  (drv_en_q),
        .drv_val_q (drv_val_q),
        .sense_q   (sense_q),
        .irq_en    (irq_en)
    );

    assign win_pins = pin_sync[IRQ_BASE +: IRQ_COUNT];

    gpio_irqwin_irqmap #(.IRQ_COUNT(IRQ_COUNT)) u_irqmap (
        .win_pins (win_pins),
        .sense    (sense_q),
        .irq_en   (irq_en),
        .irq_out  (irq_out)
    );

    assign pad_out = drv_val_q;
    assign pad_oe  = drv_en_q;

endmodule

// File: rtl/gpio_irqwin_chk.sv
// Checker for gpio_irqwin: reset state, pad-enable causality, register
// decode and interrupt window rules. Attached to the top by bind.
module gpio_irqwin_chk
    import gpio_irqwin_pkg::*;
#(
    parameter int NUM_PINS  = 22,
    parameter int IRQ_COUNT = 6,
    parameter int IRQ_BASE  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_PINS-1:0]  pad_oe,
    input logic [NUM_PINS-1:0]  pin_sync,
    input logic [IRQ_COUNT-1:0] irq_out,
    input logic [IRQ_COUNT-1:0] irq_en,
    input logic [IRQ_COUNT-1:0] sense_q
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && irq_out == '0));

    p_oe_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> $past(wr_en && decode(addr) == SEL_DRVEN));

    p_pins_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        decode(addr) == SEL_PINS |-> (rdata >> NUM_PINS) == '0);

    p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= $countones(irq_en));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decode(addr) == SEL_NONE |-> rdata == '0);

    for (genvar n = 0; n < IRQ_COUNT; n++) begin : g_idx
        p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en[n] |-> !irq_out[n]);

        p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_en[n] && $stable(irq_en[n]) && $stable(sense_q[n])
            && !$stable(pin_sync[IRQ_BASE+n]) |-> !$stable(irq_out[n]));
    end

endmodule

bind gpio_irqwin gpio_irqwin_chk #(
    .NUM_PINS  (NUM_PINS),
    .IRQ_COUNT (IRQ_COUNT),
    .IRQ_BASE  (IRQ_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .pad_oe   (pad_oe),
    .pin_sync (pin_sync),
    .irq_out  (irq_out),
    .irq_en   (irq_en),
    .sense_q  (sense_q)
);

// File: tb/test_gpio_irqwin.sv
// Scoreboard bench for gpio_irqwin: driver tasks queue expected values,
// a monitor process pops and compares them against the ports.
module test_gpio_irqwin;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 22;
    localparam int NI = 6;
    localparam int NB = 8;

    localparam logic [11:0] A_SENSE = 12'h290;
    localparam logic [11:0] A_FSEL  = 12'h294;
    localparam logic [11:0] A_DRVEN = 12'h29C;
    localparam logic [11:0] A_DRVAL = 12'h2A0;
    localparam logic [11:0] A_PINS  = 12'h2A4;
    localparam logic [11:0] A_HOLE  = 12'h298;

    localparam int SRC_RDATA = 0;
    localparam int SRC_IRQ   = 1;
    localparam int SRC_OE    = 2;
    localparam int SRC_OUT   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NI-1:0] irq_out;

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sb_ev;
    int       n_chk = 0;
    int       n_fail = 0;
    bit       done = 1'b0;

    gpio_irqwin i_gpio_irqwin (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .irq_out (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected interrupt vector from the routing, sense and pad rules.
    function automatic logic [31:0] exp_irq(input logic [31:0] fsel,
                                            input logic [31:0] sense,
                                            input logic [NP-1:0] pads);
        logic [31:0] r = '0;
        for (int n = 0; n < NI; n++) begin
            logic lvl;
            lvl  = sense[n] ? pads[NB+n] : ~pads[NB+n];
            r[n] = fsel[2*(NB+n)] & lvl;
        end
        return r;
    endfunction

    task automatic expect_val(input int src, input logic [31:0] exp,
                              input string tag);
        sb_item_t it;
        it.src = src;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
        #2;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp,
                      input string tag);
        @(negedge clk);
        addr = a;
        expect_val(SRC_RDATA, exp, tag);
    endtask

    task automatic chk_port(input int src, input logic [31:0] exp,
                            input string tag);
        @(negedge clk);
        expect_val(src, exp, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = '0;
    endtask

    task automatic set_pads(input logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (2) @(posedge clk);
    endtask

    // Monitor: pop each queued expectation and compare with the port.
    initial begin
        forever begin
            @(sb_ev);
            #1;
            while (sb_q.size() != 0) begin
                sb_item_t    it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.src)
                    SRC_RDATA: act = rdata;
                    SRC_IRQ:   act = 32'(irq_out);
                    SRC_OE:    act = 32'(pad_oe);
                    default:   act = 32'(pad_out);
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] fsel;
        logic [31:0] sense;
        logic [NP-1:0] pads;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_SENSE, 32'h0, "R1 sense after reset");
        rd(A_FSEL,  32'h0, "R1 fsel after reset");
        rd(A_DRVEN, 32'h0, "R1 drive enable after reset");
        rd(A_DRVAL, 32'h0, "R1 drive value after reset");
        chk_port(SRC_OE,  32'h0, "R1 pad_oe after reset");
        chk_port(SRC_IRQ, 32'h0, "R1 irq_out after reset");

        // R2: drive registers and pad outputs
        wr(A_DRVEN, 32'hFFFF_FFFF);
        rd(A_DRVEN, 32'h003F_FFFF, "R2 drive enable readback");
        chk_port(SRC_OE, 32'h003F_FFFF, "R2 pad_oe all");
        wr(A_DRVAL, 32'hA5A5_A5A5);
        rd(A_DRVAL, 32'h0025_A5A5, "R2 drive value readback");
        chk_port(SRC_OUT, 32'h0025_A5A5, "R2 pad_out");
        wr(A_DRVEN, 32'h0000_F0F0);
        chk_port(SRC_OE, 32'h0000_F0F0, "R2 pad_oe partial");

        // R3: synchronizer latency and read-only input register
        @(negedge clk);
        pad_in = 22'h15_5555;
        @(posedge clk);
        rd(A_PINS, 32'h0, "R3 pins after one edge");
        rd(A_PINS, 32'h0015_5555, "R3 pins after two edges");
        wr(A_PINS, 32'hFFFF_FFFF);
        rd(A_PINS, 32'h0015_5555, "R3 write to input register ignored");
        set_pads(22'h3F_FFFF);
        rd(A_PINS, 32'h003F_FFFF, "R3 pins all high");

        // R9: other registers untouched by a sense write
        sense = 32'h0000_002A;
        wr(A_SENSE, 32'hFFFF_FFEA);
        rd(A_SENSE, sense, "R5 sense holds bits 0..5 only");
        rd(A_DRVEN, 32'h0000_F0F0, "R9 drive enable kept after sense write");
        rd(A_DRVAL, 32'h0025_A5A5, "R9 drive value kept after sense write");

        // R4/R5: route all window pins, mixed sense
        fsel = 32'h0555_0000;
        wr(A_FSEL, fsel);
        rd(A_FSEL, fsel, "R4 fsel readback");
        pads = 22'h00_0000;
        set_pads(pads);
        chk_port(SRC_IRQ, exp_irq(fsel, sense, pads), "R5 window pads low");
        pads = 22'h00_3F00;
        set_pads(pads);
        chk_port(SRC_IRQ, exp_irq(fsel, sense, pads), "R5 window pads high");
        pads = 22'h00_0F00;
        set_pads(pads);
        chk_port(SRC_IRQ, exp_irq(fsel, sense, pads), "R5 mixed pads");
        sense = 32'h0000_0015;
        wr(A_SENSE, sense);
        chk_port(SRC_IRQ, exp_irq(fsel, sense, pads), "R5 flipped sense");

        // R6: one index unrouted
        fsel = 32'h0545_0000;
        wr(A_FSEL, fsel);
        pads = 22'h00_0000;
        set_pads(pads);
        chk_port(SRC_IRQ, exp_irq(fsel, sense, pads), "R6 index 2 held low, pads low");
        pads = 22'h3F_FFFF;
        set_pads(pads);
        chk_port(SRC_IRQ, exp_irq(fsel, sense, pads), "R6 index 2 held low, pads high");

        // R7: routing bits only outside the window
        fsel = 32'h5000_5555;
        wr(A_FSEL, fsel);
        chk_port(SRC_IRQ, 32'h0, "R7 out-of-window pads high");
        set_pads(22'h00_0000);
        chk_port(SRC_IRQ, 32'h0, "R7 out-of-window pads low");
        wr(A_SENSE, 32'h0);
        set_pads(22'h15_5555);
        chk_port(SRC_IRQ, 32'h0, "R7 out-of-window inverted sense");

        // R8: unmapped offset
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_HOLE, 32'h0, "R8 unmapped read zero");
        rd(12'h000, 32'h0, "R8 offset zero reads zero");
        rd(A_FSEL, fsel, "R8 fsel kept after unmapped write");
        rd(A_DRVEN, 32'h0000_F0F0, "R8 drive enable kept after unmapped write");
        rd(A_SENSE, 32'h0, "R8 sense kept after unmapped write");
        chk_port(SRC_IRQ, 32'h0, "R8 irq kept after unmapped write");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule